// File: doc/BRIEF.md
# Full-Bridge Commutation Sequencer

This block drives the four gate enables of an H-bridge (high and low switch on the left leg, high and low switch on the right leg). Once the supply is qualified, it alternates between the two diagonal pairs: high-left with low-right (pair A) and high-right with low-left (pair B). Every changeover passes through a non-overlap gap of `DEAD_CYCLES` system clocks in which all four gates are off. Before the supply qualifies, and while a delayed-start request is held, the block keeps both low sides on and both high sides off. This lets the bootstrap capacitors charge while no current flows through the load. A bridge-disable input turns every gate off and takes priority over everything else.

The commutation source `driveIn` is asynchronous. It is either an oscillator tick or an external drive waveform. It passes through a synchronizer and an edge detector. A strap input selects one of two modes. With the divider in use, each falling edge swaps the pair, which gives half the source frequency at an exact 50% duty. With the divider bypassed, the pair follows the drive level directly.

Top module: `hbridge_sequencer`

## Requirements
- R1: While `rstN` is low, the gates show the start-up pattern: high-left 0, low-left 1, high-right 0, low-right 1.
- R2: Until `supplyRelease` has been seen high, the gates show the start-up pattern. A high `supplyReset` returns the block to start-up two clock edges later and wins when both qualifiers are high. Once released, a low `supplyRelease` on its own does not stop the bridge.
- R3: One clock edge after `bridgeOff` is sampled high, all four gates are 0. This holds whatever the supply, delayed-start and run state.
- R4: On leaving start-up, disable or delayed start with the divider in use (`divBypass` = 0), the block first shows `DEAD_CYCLES` cycles with all gates off and then turns on pair A.
- R5: With the divider in use, each falling edge of `driveIn` swaps the active pair, and rising edges have no effect. A fall applied before clock edge 1 gives all-off after edge 4.
- R6: With the divider bypassed (`divBypass` = 1), a high drive level selects pair A and a low level selects pair B, after the non-overlap gap.
- R7: The only gate patterns are the start-up pattern, all off, pair A and pair B. One leg never has both switches on, and both high sides are never on together.
- R8: Every change from one pair to the other is separated by exactly `DEAD_CYCLES` cycles with all gates off.
- R9: A commutation request that arrives during a gap is applied after the gap ends. The pair selected by that gap is on for at least one cycle, and then a new gap follows.
- R10: While `holdStart` is high, the gates show the start-up pattern. On release, the sequence restarts through a gap at the defined first position.
- R11: `driveIn` passes two synchronizer flops. With the divider bypassed, a level change applied before clock edge 1 leaves the old pair on after edges 1 and 2 and gives all-off after edge 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyRelease | input | 1 | Supply is above the release level |
| supplyReset | input | 1 | Supply has fallen below the reset level |
| bridgeOff | input | 1 | Bridge disable, all gates off |
| holdStart | input | 1 | Delayed start, hold the start-up pattern |
| divBypass | input | 1 | Strap: 1 = pair follows the drive level, 0 = divide by two |
| driveIn | input | 1 | Asynchronous oscillator tick or external drive |
| gateHiLeft | output | 1 | High-side left gate enable |
| gateLoLeft | output | 1 | Low-side left gate enable |
| gateHiRight | output | 1 | High-side right gate enable |
| gateLoRight | output | 1 | Low-side right gate enable |

## Verification
The assertions assume that `divBypass` is a static strap. It changes only while the block sits in start-up or disable, so a mode switch never forces a pair change outside a gap. They also assume that each `driveIn` level lasts at least one clock, so that the synchronizer sees every edge. The stimulus changes the strap only under `holdStart` and holds every drive level for at least one clock. It deliberately places one short drive pulse inside a gap to exercise the deferred request.

// File: rtl/hbridge_pkg.sv
package hbridge_pkg;

  typedef enum logic [1:0] {
    MODE_START = 2'd0,
    MODE_OFF   = 2'd1,
    MODE_GAP   = 2'd2,
    MODE_RUN   = 2'd3
  } bridge_mode_t;

  // strobes from control to datapath
  typedef struct packed {
    bridge_mode_t mode;
    logic         gapStart;
    logic         restart;
  } ctrl_strobe_t;

  // gate vector order: {hiLeft, loLeft, hiRight, loRight}
  localparam logic [3:0] GATES_START = 4'b0101;
  localparam logic [3:0] GATES_NONE  = 4'b0000;
  localparam logic [3:0] GATES_PAIRA = 4'b1001;
  localparam logic [3:0] GATES_PAIRB = 4'b0110;

endpackage

// File: rtl/hbridge_sync.sv
module hbridge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hbridge_datapath.sv
module hbridge_datapath
  import hbridge_pkg::*;
#(
  parameter int DEAD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         driveIn,
  input  logic         divBypass,
  input  ctrl_strobe_t strobe,
  output logic         gapDone,
  output logic         phaseMismatch,
  output logic [3:0]   gates
);
  localparam int CNT_W = (DEAD_CYCLES < 1) ? 1 : $clog2(DEAD_CYCLES + 1);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(DEAD_CYCLES - 1);

  logic driveLevel, driveLast, driveFall;
  logic toggleQ, targetPhase, phaseQ;
  logic [CNT_W-1:0] gapCnt;

  hbridge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(driveIn), .syncOut(driveLevel)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) driveLast <= 1'b0;
    else       driveLast <= driveLevel;
  end

  assign driveFall = driveLast & ~driveLevel;

  // divide-by-two state: 0 selects pair A, 1 selects pair B
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      toggleQ <= 1'b0;
    else if (strobe.restart || strobe.mode == MODE_START || strobe.mode == MODE_OFF)
      toggleQ <= 1'b0;
    else if (driveFall)
      toggleQ <= ~toggleQ;
  end

  assign targetPhase = divBypass ? ~driveLevel : toggleQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseQ <= 1'b0;
    else if (strobe.restart)  phaseQ <= divBypass ? ~driveLevel : 1'b0;
    else if (strobe.gapStart) phaseQ <= targetPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      gapCnt <= '0;
    else if (strobe.gapStart || strobe.restart)
      gapCnt <= GAP_LOAD;
    else if (strobe.mode == MODE_GAP && gapCnt != '0)
      gapCnt <= gapCnt - 1'b1;
  end

  assign gapDone       = (gapCnt == '0);
  assign phaseMismatch = (targetPhase != phaseQ);

  always_comb begin
    unique case (strobe.mode)
      MODE_START: gates = GATES_START;
      MODE_OFF:   gates = GATES_NONE;
      MODE_GAP:   gates = GATES_NONE;
      MODE_RUN:   gates = phaseQ ? GATES_PAIRB : GATES_PAIRA;
      default:    gates = GATES_NONE;
    endcase
  end
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hbridge_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         supplyRelease,
  input  logic         supplyReset,
  input  logic         bridgeOff,
  input  logic         holdStart,
  input  logic         gapDone,
  input  logic         phaseMismatch,
  output ctrl_strobe_t strobe
);
  bridge_mode_t modeQ, modeD;
  logic poweredQ, gapStart, restart;

  // supply hysteresis: reset level wins over release level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              poweredQ <= 1'b0;
    else if (supplyReset)   poweredQ <= 1'b0;
    else if (supplyRelease) poweredQ <= 1'b1;
  end

  always_comb begin
    modeD    = modeQ;
    gapStart = 1'b0;
    restart  = 1'b0;
    if (bridgeOff) begin
      modeD = MODE_OFF;
    end else if (!poweredQ || holdStart) begin
      modeD = MODE_START;
    end else begin
      unique case (modeQ)
        MODE_START, MODE_OFF: begin
          modeD   = MODE_GAP;
          restart = 1'b1;
        end
        MODE_GAP: if (gapDone) modeD = MODE_RUN;
        MODE_RUN: if (phaseMismatch) begin
          modeD    = MODE_GAP;
          gapStart = 1'b1;
        end
        default: modeD = MODE_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_START;
    else       modeQ <= modeD;
  end

  assign strobe = '{mode: modeQ, gapStart: gapStart, restart: restart};
endmodule

// File: rtl/hbridge_sequencer.sv
module hbridge_sequencer
  import hbridge_pkg::*;
#(
  parameter int DEAD_CYCLES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic supplyRelease,
  input  logic supplyReset,
  input  logic bridgeOff,
  input  logic holdStart,
  input  logic divBypass,
  input  logic driveIn,
  output logic gateHiLeft,
  output logic gateLoLeft,
  output logic gateHiRight,
  output logic gateLoRight
);
  ctrl_strobe_t strobe;
  logic gapDone, phaseMismatch;
  logic [3:0] gates;

  hbridge_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .supplyRelease(supplyRelease), .supplyReset(supplyReset),
    .bridgeOff(bridgeOff), .holdStart(holdStart),
    .gapDone(gapDone), .phaseMismatch(phaseMismatch),
    .strobe(strobe)
  );

  hbridge_datapath #(.DEAD_CYCLES(DEAD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .driveIn(driveIn), .divBypass(divBypass),
    .strobe(strobe), .gapDone(gapDone), .phaseMismatch(phaseMismatch),
    .gates(gates)
  );

  assign {gateHiLeft, gateLoLeft, gateHiRight, gateLoRight} = gates;
endmodule

// File: rtl/hbridge_checker.sv
module hbridge_checker (
  input logic clk,
  input logic rstN,
  input logic supplyReset,
  input logic bridgeOff,
  input logic gateHiLeft,
  input logic gateLoLeft,
  input logic gateHiRight,
  input logic gateLoRight
);
  logic isStart, isPairA, isPairB, allOff;
  assign isStart = !gateHiLeft && gateLoLeft && !gateHiRight && gateLoRight;
  assign isPairA = gateHiLeft && !gateLoLeft && !gateHiRight && gateLoRight;
  assign isPairB = !gateHiLeft && gateLoLeft && gateHiRight && !gateLoRight;
  assign allOff  = !gateHiLeft && !gateLoLeft && !gateHiRight && !gateLoRight;

  p_legal_pattern_r7: assert property (@(posedge clk) disable iff (!rstN)
    isStart || isPairA || isPairB || allOff);

  p_no_shoot_through_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHiLeft && gateLoLeft) && !(gateHiRight && gateLoRight));

  p_a_to_b_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    isPairA |=> !isPairB);

  p_b_to_a_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    isPairB |=> !isPairA);

  p_disable_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    bridgeOff |=> allOff);

  p_supply_drop_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(supplyReset) && !bridgeOff) |=> isStart);

  p_start_through_gap_r4: assert property (@(posedge clk) disable iff (!rstN)
    isStart |=> !(isPairA || isPairB));
endmodule

bind hbridge_sequencer hbridge_checker u_checker (
  .clk(clk), .rstN(rstN), .supplyReset(supplyReset), .bridgeOff(bridgeOff),
  .gateHiLeft(gateHiLeft), .gateLoLeft(gateLoLeft),
  .gateHiRight(gateHiRight), .gateLoRight(gateLoRight)
);

// File: tb/hbridge_sequencer_test.sv
module hbridge_sequencer_test;
  localparam int DT = 3;
  localparam logic [3:0] P_START = 4'b0101;
  localparam logic [3:0] P_NONE  = 4'b0000;
  localparam logic [3:0] P_A     = 4'b1001;
  localparam logic [3:0] P_B     = 4'b0110;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyRelease = 1'b0, supplyReset = 1'b0, bridgeOff = 1'b0;
  logic holdStart = 1'b0, divBypass = 1'b0, driveIn = 1'b0;
  logic gateHiLeft, gateLoLeft, gateHiRight, gateLoRight;
  int checks = 0;
  int fails = 0;
  logic [3:0] cur;
  logic done = 1'b0;

  always #4 clk = ~clk;

  hbridge_sequencer #(.DEAD_CYCLES(DT), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .supplyRelease(supplyRelease), .supplyReset(supplyReset),
    .bridgeOff(bridgeOff), .holdStart(holdStart), .divBypass(divBypass), .driveIn(driveIn),
    .gateHiLeft(gateHiLeft), .gateLoLeft(gateLoLeft),
    .gateHiRight(gateHiRight), .gateLoRight(gateLoRight)
  );

  wire [3:0] gates = {gateHiLeft, gateLoLeft, gateHiRight, gateLoRight};

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (gates !== exp) begin
      fails++;
      $display("FAIL %s: gates=%b expected=%b at %0t", req, gates, exp, $time);
    end
  endtask

  // DT all-off samples then the given pair
  task automatic gapThen(input string req, input logic [3:0] pat);
    for (int i = 0; i < DT; i++) begin
      tick();
      check(req, P_NONE);
    end
    tick();
    check(req, pat);
    cur = pat;
  endtask

  // divider mode: one falling edge of the drive swaps the pair
  task automatic divFall(input int highLen);
    logic [3:0] nxt;
    nxt = (cur == P_A) ? P_B : P_A;
    driveIn = 1'b1;
    for (int i = 0; i < highLen; i++) begin
      tick();
      check("R5 rise ignored", cur);
    end
    driveIn = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R5 fall latency", cur);
    end
    gapThen("R5 R8 swap", nxt);
  endtask

  // R7 legality sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (!(gates == P_START || gates == P_NONE || gates == P_A || gates == P_B)) begin
        fails++;
        $display("FAIL R7: gates=%b expected one of 0101/0000/1001/0110", gates);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check("R1 reset pattern", P_START);
    rstN = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      check("R2 unreleased supply", P_START);
    end

    supplyRelease = 1'b1;
    tick();
    check("R2 release latency", P_START);
    gapThen("R4 first position", P_A);

    supplyRelease = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R2 release latched", P_A);
    end

    for (int k = 0; k < 4; k++) divFall(2 + k);

    // R9: second fall lands inside the gap
    begin
      logic [3:0] x, y;
      x = cur;
      y = (cur == P_A) ? P_B : P_A;
      driveIn = 1'b1;
      repeat (4) tick();
      driveIn = 1'b0;
      tick(); check("R9 prev", x);
      tick(); check("R9 prev", x);
      driveIn = 1'b1;
      tick(); check("R9 prev", x);
      driveIn = 1'b0;
      for (int i = 0; i < 3; i++) begin
        tick();
        check("R9 first gap", P_NONE);
      end
      tick(); check("R9 pair held one cycle", y);
      gapThen("R9 deferred swap", x);
    end

    if (cur == P_A) divFall(3);
    bridgeOff = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 disable", P_NONE);
    end
    bridgeOff = 1'b0;
    gapThen("R4 after disable", P_A);

    divFall(2);
    holdStart = 1'b1;
    for (int i = 0; i < 2; i++) begin
      tick();
      check("R10 hold", P_START);
    end
    holdStart = 1'b0;
    gapThen("R10 restart position", P_A);

    holdStart = 1'b1;
    bridgeOff = 1'b1;
    tick(); check("R3 over start-up", P_NONE);
    bridgeOff = 1'b0;
    tick(); check("R3 release to start-up", P_START);

    divBypass = 1'b1;
    driveIn = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R10 hold", P_START);
    end
    holdStart = 1'b0;
    gapThen("R6 low level", P_B);
    for (int w = 0; w < 5; w++) begin
      logic [3:0] old, nxt;
      old = cur;
      driveIn = ~driveIn;
      nxt = driveIn ? P_A : P_B;
      tick(); check("R11 sync edge 1", old);
      tick(); check("R11 sync edge 2", old);
      gapThen("R6 level follow", nxt);
      for (int i = 0; i < w; i++) begin
        tick();
        check("R6 level hold", nxt);
      end
    end

    holdStart = 1'b1;
    tick(); check("R10 hold", P_START);
    divBypass = 1'b0;
    holdStart = 1'b0;
    gapThen("R4 divider restart", P_A);

    supplyRelease = 1'b1;
    supplyReset = 1'b1;
    tick(); check("R2 drop latency", P_A);
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R2 reset wins", P_START);
    end
    supplyReset = 1'b0;
    tick(); check("R2 re-release latency", P_START);
    gapThen("R2 R4 restart", P_A);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule